// File: doc/BRIEF.md
# Multiplexed LCD Drive Waveform Sequencer

This block produces, one timeslot at a time, the drive level codes for the backplane and segment electrodes of a passive LCD panel. A display memory of 80 words of 4 bits holds the image. Each word belongs to one segment electrode, and bit b of that word turns on the element where that segment crosses backplane b. A slot tick steps the sequencer through the timeslots of a frame, with one timeslot for each backplane in use. The polarity of the drive reverses on every frame, so that no element sees a net DC voltage.

The host selects the drive mode: static, or 1:2, 1:3 or 1:4 multiplexing. It also requests a bias scheme and can blank the panel with an enable flag. Every output is a 2-bit level code:

- 00 means ground.
- 01 means the lower intermediate tap.
- 10 means the upper intermediate tap.
- 11 means the full LCD supply.

An external analog stage maps these codes onto the supply taps. Under half bias it maps both intermediate codes to the half level. The block reports the bias it has applied on `bias_out` so that this stage can set up its divider.

Top module: `lcd_wave_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, every backplane and segment code is 11. The applied mode is 1:4 with slot 0 and positive polarity, and `bias_out` is 10 (one-third bias).
- R2: While `disp_en` is low, every backplane and segment code is 11 one cycle later, whatever the memory and sequencer state.
- R3: Each `slot_tick` advances the timeslot. A frame has 1, 2, 3 or 4 timeslots for `mode_req` codes 00 (static), 01 (1:2), 10 (1:3) and 11 (1:4). In its own timeslot a used backplane is 11 in a positive frame and 00 in a negative frame. In other timeslots it is 01 in a positive frame and 10 in a negative frame.
- R4: At the end of each frame the polarity inverts, provided the requested mode and bias equal the applied ones. Inversion swaps 00 with 11 and 01 with 10.
- R5: A segment whose memory bit for the active backplane is 1 takes the extreme opposite to that backplane: 00 in positive frames and 11 in negative frames.
- R6: In the multiplexed modes, a segment whose bit is 0 takes the intermediate level nearest the active backplane: 10 in positive frames and 01 in negative frames.
- R7: In static mode, backplane 0 alternates between 11 and 00 on every tick. An on segment is driven opposite to backplane 0 and an off segment is driven equal to it.
- R8: Backplanes whose index exceeds the last slot of the applied mode carry the same code as backplane 0.
- R9: `mode_req` and `bias_req` take effect only on the tick that ends a frame. If either differs from the applied value, the new frame starts at slot 0 with positive polarity.
- R10: In static mode `bias_out` is 00. In the multiplexed modes a bias request of 01 gives 01 (half), and any other request gives 10 (one third). The output follows the applied settings one cycle later.
- R11: A write with `wr_en` high stores `wr_data` at `wr_addr`, where bit b is backplane b. The new word drives the segment outputs from the second cycle after the write. Writes to addresses 80 and above change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_tick | input | 1 | One-cycle pulse that advances the timeslot |
| mode_req | input | 2 | Requested drive mode: 00 static, 01 1:2, 10 1:3, 11 1:4 |
| bias_req | input | 2 | Requested bias: 01 half, 10 one third, other values as in R10 |
| disp_en | input | 1 | Display enable; low forces all outputs to 11 |
| wr_en | input | 1 | Display memory write strobe |
| wr_addr | input | 7 | Segment word address |
| wr_data | input | 4 | Segment word, bit b for backplane b |
| bp_lvl | output | 8 | Backplane level codes, backplane b at bits 2b+1:2b |
| seg_lvl | output | 160 | Segment level codes, segment s at bits 2s+1:2s |
| bias_out | output | 2 | Applied bias: 00 static, 01 half, 10 one third |

## Verification
The settings, the timeslot and the polarity all change on the clock edge at which the tick is sampled. The level codes are registered from that state, so any effect of a tick, a write, a mode change or the enable shows at the ports on the following edge. The reference model in the bench follows the same rule: at each rising edge it first forms the expected outputs from the model state as it stood before that edge, and only then applies the edge's inputs to the state and memory. Outputs are compared with the model at every falling edge. Further direct checks on blanking, bias reporting and backplane mirroring sample at least two edges after their stimulus.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;
  localparam logic [1:0] LVL_GND  = 2'b00;
  localparam logic [1:0] LVL_LO   = 2'b01;
  localparam logic [1:0] LVL_HI   = 2'b10;
  localparam logic [1:0] LVL_FULL = 2'b11;

  localparam logic [1:0] MODE_STATIC = 2'b00;
  localparam logic [1:0] MODE_MUX4   = 2'b11;

  localparam logic [1:0] BIAS_STATIC = 2'b00;
  localparam logic [1:0] BIAS_HALF   = 2'b01;
  localparam logic [1:0] BIAS_THIRD  = 2'b10;

  // Inverting a code swaps the two extremes and the two intermediate taps.
  function automatic logic [1:0] polarize(input logic [1:0] lvl, input logic neg);
    return neg ? ~lvl : lvl;
  endfunction
endpackage

// File: rtl/lcdw_timing.sv
module lcdw_timing #(
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_tick,
  input  logic [SLOT_W-1:0] mode_req,
  input  logic [1:0]        bias_req,
  output logic [SLOT_W-1:0] mode_q,
  output logic [1:0]        bias_q,
  output logic [SLOT_W-1:0] slot_q,
  output logic              pol_q
);
  import lcdw_pkg::*;

  logic frame_end;
  logic cfg_change;

  assign frame_end  = slot_tick && (slot_q == mode_q);
  assign cfg_change = (mode_req != mode_q) || (bias_req != bias_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= SLOT_W'(MODE_MUX4);
      bias_q <= BIAS_THIRD;
      slot_q <= '0;
      pol_q  <= 1'b0;
    end else if (frame_end) begin
      slot_q <= '0;
      mode_q <= mode_req;
      bias_q <= bias_req;
      pol_q  <= cfg_change ? 1'b0 : ~pol_q;
    end else if (slot_tick) begin
      slot_q <= slot_q + SLOT_W'(1);
    end
  end

  AST_SLOT_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    slot_q <= mode_q) else $error("slot beyond frame"); // R3

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    !(slot_tick && slot_q == mode_q) |=> ($stable(mode_q) && $stable(bias_q)))
    else $error("settings changed mid-frame"); // R9

  AST_RESTART_POSITIVE: assert property (@(posedge clk) disable iff (rst)
    (slot_tick && slot_q == mode_q && mode_req != mode_q) |=> (slot_q == '0 && !pol_q))
    else $error("mode change did not restart frame"); // R9

  AST_POL_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (slot_tick && slot_q == mode_q && mode_req == mode_q && bias_req == bias_q)
    |=> (pol_q != $past(pol_q))) else $error("polarity not inverted"); // R4
endmodule

// File: rtl/lcdw_dispmem.sv
module lcdw_dispmem #(
  parameter int NUM_SEG = 80,
  parameter int NUM_BP  = 4,
  parameter int ADDR_W  = 7
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [NUM_BP-1:0]         wr_data,
  output logic [NUM_SEG*NUM_BP-1:0] rd_flat
);
  logic [NUM_BP-1:0] mem [NUM_SEG];
  logic              in_range;

  assign in_range = {1'b0, wr_addr} < (ADDR_W+1)'(NUM_SEG);

  always_ff @(posedge clk) begin
    if (wr_en && in_range) mem[wr_addr] <= wr_data;
  end

  for (genvar j = 0; j < NUM_SEG; j++) begin : g_rd
    assign rd_flat[j*NUM_BP +: NUM_BP] = mem[j];
  end
endmodule

// File: rtl/lcdw_levelgen.sv
module lcdw_levelgen #(
  parameter int NUM_SEG = 80,
  parameter int NUM_BP  = 4,
  parameter int SLOT_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      disp_en,
  input  logic [SLOT_W-1:0]         mode_q,
  input  logic [1:0]                bias_q,
  input  logic [SLOT_W-1:0]         slot_q,
  input  logic                      pol_q,
  input  logic [NUM_SEG*NUM_BP-1:0] rd_flat,
  output logic [2*NUM_BP-1:0]       bp_lvl,
  output logic [2*NUM_SEG-1:0]      seg_lvl,
  output logic [1:0]                bias_out
);
  import lcdw_pkg::*;

  logic is_static;
  assign is_static = (mode_q == SLOT_W'(MODE_STATIC));

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    localparam logic [SLOT_W-1:0] IDX = SLOT_W'(i);
    logic [SLOT_W-1:0] src;
    logic [1:0]        lvl_d;
    logic [1:0]        lvl_q;

    always_comb begin
      src   = (IDX > mode_q) ? '0 : IDX;
      lvl_d = polarize((src == slot_q) ? LVL_FULL : LVL_LO, pol_q);
    end

    always_ff @(posedge clk) begin
      if (rst || !disp_en) lvl_q <= LVL_FULL;
      else                 lvl_q <= lvl_d;
    end
    assign bp_lvl[2*i +: 2] = lvl_q;

    if (i > 0) begin : g_chk
      AST_UNUSED_MIRROR: assert property (@(posedge clk) disable iff (rst)
        (IDX > mode_q) |=> (lvl_q == bp_lvl[1:0]))
        else $error("unused backplane differs from backplane 0"); // R8
    end
  end

  for (genvar j = 0; j < NUM_SEG; j++) begin : g_seg
    logic [NUM_BP-1:0] word;
    logic [1:0]        lvl_d;
    logic [1:0]        lvl_q;

    assign word = rd_flat[j*NUM_BP +: NUM_BP];

    always_comb begin
      if (word[slot_q])   lvl_d = LVL_GND;
      else if (is_static) lvl_d = LVL_FULL;
      else                lvl_d = LVL_HI;
      lvl_d = polarize(lvl_d, pol_q);
    end

    always_ff @(posedge clk) begin
      if (rst || !disp_en) lvl_q <= LVL_FULL;
      else                 lvl_q <= lvl_d;
    end
    assign seg_lvl[2*j +: 2] = lvl_q;
  end

  always_ff @(posedge clk) begin
    if (rst)                    bias_out <= BIAS_THIRD;
    else if (is_static)         bias_out <= BIAS_STATIC;
    else if (bias_q == BIAS_HALF) bias_out <= BIAS_HALF;
    else                        bias_out <= BIAS_THIRD;
  end

  AST_BLANK_FULL: assert property (@(posedge clk) disable iff (rst)
    !disp_en |=> ((&bp_lvl) && (&seg_lvl))) else $error("blanked output not full"); // R2

  AST_STATIC_BIAS: assert property (@(posedge clk) disable iff (rst)
    is_static |=> (bias_out == BIAS_STATIC)) else $error("static mode bias wrong"); // R10

  AST_STATIC_BP_EXTREME: assert property (@(posedge clk) disable iff (rst)
    is_static |=> (bp_lvl[1:0] == LVL_GND || bp_lvl[1:0] == LVL_FULL))
    else $error("static backplane at intermediate level"); // R7
endmodule

// File: rtl/lcd_wave_seq.sv
module lcd_wave_seq #(
  parameter int NUM_SEG = 80,
  parameter int NUM_BP  = 4,
  parameter int ADDR_W  = $clog2(NUM_SEG)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 slot_tick,
  input  logic [1:0]           mode_req,
  input  logic [1:0]           bias_req,
  input  logic                 disp_en,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [NUM_BP-1:0]    wr_data,
  output logic [2*NUM_BP-1:0]  bp_lvl,
  output logic [2*NUM_SEG-1:0] seg_lvl,
  output logic [1:0]           bias_out
);
  localparam int SLOT_W = $clog2(NUM_BP);

  logic [SLOT_W-1:0]         mode_q;
  logic [1:0]                bias_q;
  logic [SLOT_W-1:0]         slot_q;
  logic                      pol_q;
  logic [NUM_SEG*NUM_BP-1:0] rd_flat;

  lcdw_timing #(.SLOT_W(SLOT_W)) u_timing (
    .clk       (clk),
    .rst       (rst),
    .slot_tick (slot_tick),
    .mode_req  (mode_req[SLOT_W-1:0]),
    .bias_req  (bias_req),
    .mode_q    (mode_q),
    .bias_q    (bias_q),
    .slot_q    (slot_q),
    .pol_q     (pol_q)
  );

  lcdw_dispmem #(.NUM_SEG(NUM_SEG), .NUM_BP(NUM_BP), .ADDR_W(ADDR_W)) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_flat (rd_flat)
  );

  lcdw_levelgen #(.NUM_SEG(NUM_SEG), .NUM_BP(NUM_BP), .SLOT_W(SLOT_W)) u_lvl (
    .clk      (clk),
    .rst      (rst),
    .disp_en  (disp_en),
    .mode_q   (mode_q),
    .bias_q   (bias_q),
    .slot_q   (slot_q),
    .pol_q    (pol_q),
    .rd_flat  (rd_flat),
    .bp_lvl   (bp_lvl),
    .seg_lvl  (seg_lvl),
    .bias_out (bias_out)
  );

  AST_RESET_FULL: assert property (@(posedge clk)
    rst |=> ((&bp_lvl) && (&seg_lvl) && bias_out == 2'b10))
    else $error("reset state wrong"); // R1
endmodule

// File: tb/lcd_wave_seq_test.sv
module lcd_wave_seq_test;
  localparam int NS = 80;
  localparam int NB = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         slot_tick = 1'b0;
  logic [1:0]   mode_req = 2'd3;
  logic [1:0]   bias_req = 2'd2;
  logic         disp_en = 1'b0;
  logic         wr_en = 1'b0;
  logic [6:0]   wr_addr = '0;
  logic [3:0]   wr_data = '0;
  logic [7:0]   bp_lvl;
  logic [159:0] seg_lvl;
  logic [1:0]   bias_out;

  lcd_wave_seq uut (
    .clk(clk), .rst(rst), .slot_tick(slot_tick), .mode_req(mode_req),
    .bias_req(bias_req), .disp_en(disp_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .bp_lvl(bp_lvl), .seg_lvl(seg_lvl), .bias_out(bias_out)
  );

  always #5 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    done = 0;
  string phase = "R1";

  int m_mode = 3, m_bias = 2, m_slot = 0, m_pol = 0;
  int m_mem [NS];
  int e_bp [NB];
  int e_seg [NS];
  int e_bias = 2;

  initial begin
    for (int s = 0; s < NS; s++) begin m_mem[s] = 0; e_seg[s] = 3; end
    for (int b = 0; b < NB; b++) e_bp[b] = 3;
  end

  // Reference model: outputs from the state before the edge, then update.
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_mode = 3; m_bias = 2; m_slot = 0; m_pol = 0; e_bias = 2;
      for (int b = 0; b < NB; b++) e_bp[b] = 3;
      for (int s = 0; s < NS; s++) e_seg[s] = 3;
    end else begin
      if (m_mode == 0) e_bias = 0;
      else if (m_bias == 1) e_bias = 1;
      else e_bias = 2;
      for (int b = 0; b < NB; b++) begin
        int src;
        src = (b > m_mode) ? 0 : b;
        if (!disp_en) e_bp[b] = 3;
        else if (src == m_slot) e_bp[b] = m_pol ? 0 : 3;
        else e_bp[b] = m_pol ? 2 : 1;
      end
      for (int s = 0; s < NS; s++) begin
        if (!disp_en) e_seg[s] = 3;
        else if (((m_mem[s] >> m_slot) & 1) == 1) e_seg[s] = m_pol ? 3 : 0;
        else if (m_mode == 0) e_seg[s] = m_pol ? 0 : 3;
        else e_seg[s] = m_pol ? 1 : 2;
      end
      if (wr_en && wr_addr < NS) m_mem[wr_addr] = wr_data;
      if (slot_tick) begin
        if (m_slot == m_mode) begin
          if (mode_req != m_mode || bias_req != m_bias) m_pol = 0;
          else m_pol = 1 - m_pol;
          m_slot = 0;
          m_mode = mode_req;
          m_bias = bias_req;
        end else m_slot++;
      end
    end
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog (all requirements): cycles %0d expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Compare against the model on every falling edge.
  always @(negedge clk) begin
    if (!done) begin
      logic [7:0]   ebp;
      logic [159:0] eseg;
      for (int b = 0; b < NB; b++) ebp[2*b +: 2] = 2'(e_bp[b]);
      for (int s = 0; s < NS; s++) eseg[2*s +: 2] = 2'(e_seg[s]);
      checks++;
      if (bp_lvl !== ebp || seg_lvl !== eseg || bias_out !== 2'(e_bias)) begin
        errors++;
        $display("FAIL %s: bp=%h seg=%h bias=%0d expected bp=%h seg=%h bias=%0d",
                 phase, bp_lvl, seg_lvl, bias_out, ebp, eseg, e_bias);
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [159:0] act,
                       input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input int cycles, input int gap);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      slot_tick = (c % gap) == 0;
    end
    @(negedge clk);
    slot_tick = 0;
  endtask

  logic [7:0] lfsr = 8'hA5;

  initial begin
    repeat (4) @(negedge clk);
    check(bp_lvl == 8'hFF && bias_out == 2'b10, "R1 reset", {150'd0, bias_out, bp_lvl}, {150'd0, 2'b10, 8'hFF});
    rst = 0;
    @(negedge clk);
    check(&seg_lvl, "R1 after release", seg_lvl, {160{1'b1}});

    phase = "R2 blank while loading";
    for (int j = 0; j < NS; j++) begin
      wr_en = 1; wr_addr = 7'(j);
      wr_data = (j % 11 == 0) ? 4'hF : (j % 13 == 0) ? 4'h0 : 4'((j * 7 + 3) % 16);
      @(negedge clk);
    end
    phase = "R11 out of range write";
    wr_addr = 7'd100; wr_data = 4'hF; @(negedge clk);
    wr_addr = 7'd80;  wr_data = 4'hF; @(negedge clk);
    wr_addr = 7'd127; wr_data = 4'h0; @(negedge clk);
    wr_en = 0;
    check(&seg_lvl, "R2 blank", seg_lvl, {160{1'b1}});

    disp_en = 1;
    phase = "R3 R5 R6 1:4 mode";
    run(40, 1);
    phase = "R4 polarity 1:4 sparse ticks";
    run(30, 3);

    phase = "R9 change to 1:2 half bias";
    mode_req = 2'd1; bias_req = 2'd1;
    run(30, 2);
    check(bias_out == 2'b01, "R10 half bias", {158'd0, bias_out}, 160'd1);

    phase = "R10 1:3 with static bias request";
    mode_req = 2'd2; bias_req = 2'd0;
    run(36, 1);
    check(bias_out == 2'b10, "R10 static request in 1:3", {158'd0, bias_out}, 160'd2);
    check(bp_lvl[7:6] == bp_lvl[1:0], "R8 mirror in 1:3", {152'd0, bp_lvl}, {152'd0, bp_lvl[1:0], bp_lvl[5:0]});

    phase = "R7 static mode";
    mode_req = 2'd0; bias_req = 2'd2;
    run(20, 1);
    check(bias_out == 2'b00, "R10 static", {158'd0, bias_out}, 160'd0);
    check(bp_lvl == {4{bp_lvl[1:0]}}, "R8 mirror in static", {152'd0, bp_lvl}, {152'd0, {4{bp_lvl[1:0]}}});
    phase = "R7 static sparse";
    run(20, 4);

    phase = "R4 1:4 steady";
    mode_req = 2'd3; bias_req = 2'd2;
    run(40, 2);

    phase = "R11 live writes";
    for (int c = 0; c < 80; c++) begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      wr_en = 1; wr_addr = 7'(lfsr % 96); wr_data = lfsr[7:4];
      slot_tick = lfsr[0];
    end
    @(negedge clk); wr_en = 0; slot_tick = 0;

    phase = "R2 blank mid-run";
    disp_en = 0;
    run(10, 1);
    check((&seg_lvl) && (&bp_lvl), "R2 blank mid-run", seg_lvl, {160{1'b1}});
    disp_en = 1;

    phase = "R9 random mode changes";
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (c % 17 == 0) begin mode_req = lfsr[1:0]; bias_req = lfsr[3:2]; end
      slot_tick = lfsr[4] | lfsr[6];
    end
    @(negedge clk); slot_tick = 0;
    @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule